// File: doc/BRIEF.md
# Dual Down-Counting Event Timer

This peripheral holds two independent down-counters behind a small synchronous register bus. Each channel counts either a single-cycle external reference tick or the fabric clock divided by a power of two picked by a 3-bit exponent. It can run as a periodic counter that refills itself from a reload register, or as a one-shot that stops at zero. Each channel raises a sticky event bit when its count reaches zero. That bit, qualified by the channel's enable, drives an interrupt line.

Software starts a one-shot by writing the value register of an enabled channel that has auto-reload off. It builds a free-running timebase by loading all ones into both value and reload with auto-reload on, and it reads elapsed time as the bitwise inverse of the value. Bus writes land on the rising clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Each channel runs a three-state machine. STOPPED is held while the channel's enable is clear. It moves to COUNTING on the clock after the enable is seen set. In COUNTING, each qualifying tick lowers the count by one, or refills it when the count is already zero and auto-reload is on. COUNTING moves to EXPIRED when the count reaches zero with auto-reload off. EXPIRED returns to COUNTING on a write of the value register or when auto-reload is turned on. Clearing the enable sends both COUNTING and EXPIRED back to STOPPED.

Top module: `dual_dntimer`

## Requirements
- R1: After reset every register reads zero, both interrupt lines are low, and both channels are STOPPED.
- R2: The control register is at byte offset 0x00. Channel 0 uses enable bit 0, auto-reload bit 1, reference-tick select bit 11 and exponent bits 21:19. Channel 1 uses enable bit 2, auto-reload bit 3, reference-tick select bit 12 and exponent bits 24:22. All other bits read as zero.
- R3: Reload and value registers are at 0x10/0x14 for channel 0 and 0x18/0x1C for channel 1, each 32 bits wide. A write takes effect at the next clock edge, and it wins over a count in that same cycle.
- R4: While a channel is enabled, its count drops by exactly one per qualifying tick. Counting begins on the second clock after the enable is written. With the enable clear, the count does not change.
- R5: With reference-tick select set, only `ref_tick` pulses qualify. With it clear, the channel decrements exactly once in every 2^N fabric clocks, where N is its exponent field.
- R6: With auto-reload set, a qualifying tick at count zero loads the reload register. Loading 0xFFFFFFFF into both makes the counter wrap freely.
- R7: With auto-reload clear, the count stops at zero and raises its event once (EXPIRED). No further event occurs until the value register is written again.
- R8: The status register is at 0x04, with channel 0's event at bit 0 and channel 1's at bit 8. A bit is set on the edge where its count goes from one to zero. Writing 0 to a bit clears it, writing 1 leaves it unchanged, and a set in the same cycle as a clear wins.
- R9: Each interrupt line (irq_o[0] for channel 0, irq_o[1] for channel 1) is high exactly when that channel's event bit and its enable bit are both set.
- R10: Reads of any other offset, including unaligned ones, return zero, and writes to them change nothing.
- R11: The two channels are independent: traffic and ticks for one leave the other's value, reload and event untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Single-cycle fixed reference tick enable |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 2 | Interrupt per channel, bit 0 for channel 0 |

## Verification
Register writes and count steps appear one clock after the edge that samples them. Event bits and interrupts rise on that same edge. The enable is the only input with a second register in its path, so the first tick the bench sends after an enable write comes at least two edges later. All stimulus changes on the falling edge, and each value is read half a period after the edge that produced it. The prescaler's phase against the free divider is unknown, so its check reads the count twice exactly 2^N·k edges apart and expects a difference of exactly k, which does not depend on phase.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    localparam int NUM_CH   = 2;
    localparam int REG_W    = 32;
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h04;

    typedef enum logic [1:0] {
        CH_STOPPED  = 2'd0,
        CH_COUNTING = 2'd1,
        CH_EXPIRED  = 2'd2
    } ch_state_e;

    function automatic int f_en_bit(input int ch);
        return (ch == 0) ? 0 : 2;
    endfunction

    function automatic int f_rl_bit(input int ch);
        return (ch == 0) ? 1 : 3;
    endfunction

    function automatic int f_fix_bit(input int ch);
        return 11 + ch;
    endfunction

    function automatic int f_exp_lsb(input int ch, input int exp_w);
        return 19 + exp_w * ch;
    endfunction

    function automatic int f_stat_bit(input int ch);
        return 8 * ch;
    endfunction

    function automatic int f_rld_ofs(input int ch);
        return 'h10 + 8 * ch;
    endfunction

    function automatic int f_val_ofs(input int ch);
        return 'h14 + 8 * ch;
    endfunction

    function automatic logic [REG_W-1:0] f_ctrl_mask(input int exp_w);
        logic [REG_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            m[f_en_bit(c)]  = 1'b1;
            m[f_rl_bit(c)]  = 1'b1;
            m[f_fix_bit(c)] = 1'b1;
            for (int b = 0; b < exp_w; b++) begin
                m[f_exp_lsb(c, exp_w) + b] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/dtm_prescale.sv
module dtm_prescale #(
    parameter int EXP_W = 3,
    localparam int PW = (1 << EXP_W) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] free_cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_cnt <= '0;
        end else begin
            free_cnt <= free_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dtm_channel.sv
module dtm_channel
    import dtm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EXP_W = 3,
    localparam int PW = (1 << EXP_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rl_en,
    input  logic             fix_sel,
    input  logic [EXP_W-1:0] expo,
    input  logic             ref_tick,
    input  logic [PW-1:0]    free_cnt,
    input  logic             ld_val,
    input  logic             ld_rld,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             hit_o,
    output ch_state_e        state_o
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] val_q, rld_q;
    logic [PW:0]      one_sh;
    logic [PW-1:0]    pmask;
    logic             tick, count_ok, hit;

    always_comb begin
        one_sh = (PW + 1)'(1) << expo;
        pmask  = PW'(one_sh - 1'b1);
        tick   = fix_sel ? ref_tick : ((free_cnt & pmask) == pmask);
    end

    assign count_ok = (state_q == CH_COUNTING) && en && tick && !ld_val;
    assign hit      = count_ok && (val_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: begin
                if (en) state_d = CH_COUNTING;
            end
            CH_COUNTING: begin
                if (!en)               state_d = CH_STOPPED;
                else if (hit && !rl_en) state_d = CH_EXPIRED;
            end
            CH_EXPIRED: begin
                if (!en)                 state_d = CH_STOPPED;
                else if (ld_val || rl_en) state_d = CH_COUNTING;
            end
            default: state_d = CH_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (ld_val) begin
            val_q <= wdata;
        end else if (count_ok) begin
            if (val_q == '0) begin
                if (rl_en) val_q <= rld_q;
            end else begin
                val_q <= val_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (ld_rld) begin
            rld_q <= wdata;
        end
    end

    always_comb begin
        value_o  = val_q;
        reload_o = rld_q;
        hit_o    = hit;
        state_o  = state_q;
    end

endmodule

// File: rtl/dual_dntimer.sv
module dual_dntimer
    import dtm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int EXP_W  = 3,
    parameter int ADDR_W = 5,
    localparam int PW    = (1 << EXP_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);

    localparam logic [REG_W-1:0] CTRL_MASK = f_ctrl_mask(EXP_W);

    logic [REG_W-1:0]  ctrl_q;
    logic [NUM_CH-1:0] stat_q, stat_d;
    logic [NUM_CH-1:0] ch_hit;
    logic [CNT_W-1:0]  ch_val [NUM_CH];
    logic [CNT_W-1:0]  ch_rld [NUM_CH];
    ch_state_e         ch_state [NUM_CH];
    logic [PW-1:0]     free_cnt;
    logic              wr_ctrl, wr_stat;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));

    dtm_prescale #(.EXP_W(EXP_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .free_cnt (free_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= bus_wdata & CTRL_MASK;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int EN_B  = f_en_bit(g);
        localparam int RL_B  = f_rl_bit(g);
        localparam int FIX_B = f_fix_bit(g);
        localparam int EXP_L = f_exp_lsb(g, EXP_W);
        logic ld_val, ld_rld;

        assign ld_val = bus_wr && (bus_addr == ADDR_W'(f_val_ofs(g)));
        assign ld_rld = bus_wr && (bus_addr == ADDR_W'(f_rld_ofs(g)));

        dtm_channel #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ctrl_q[EN_B]),
            .rl_en    (ctrl_q[RL_B]),
            .fix_sel  (ctrl_q[FIX_B]),
            .expo     (ctrl_q[EXP_L +: EXP_W]),
            .ref_tick (ref_tick),
            .free_cnt (free_cnt),
            .ld_val   (ld_val),
            .ld_rld   (ld_rld),
            .wdata    (bus_wdata[CNT_W-1:0]),
            .value_o  (ch_val[g]),
            .reload_o (ch_rld[g]),
            .hit_o    (ch_hit[g]),
            .state_o  (ch_state[g])
        );

        assign irq_o[g] = stat_q[g] & ctrl_q[EN_B];
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            stat_d[i] = ch_hit[i] |
                        (stat_q[i] & ~(wr_stat && !bus_wdata[f_stat_bit(i)]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = ctrl_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(OFS_STAT))
                bus_rdata[f_stat_bit(i)] = stat_q[i];
            if (bus_addr == ADDR_W'(f_rld_ofs(i)))
                bus_rdata = REG_W'(ch_rld[i]);
            if (bus_addr == ADDR_W'(f_val_ofs(i)))
                bus_rdata = REG_W'(ch_val[i]);
        end
    end

endmodule

// File: rtl/dtm_chk.sv
module dtm_chk #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [1:0]        irq_o,
    input logic [CNT_W-1:0]  val0,
    input logic              en0,
    input logic              rl0,
    input logic              stat0,
    input logic              hit0
);

    logic wr_val0, clr0, mapped;
    assign wr_val0 = bus_wr && (bus_addr == ADDR_W'('h14));
    assign clr0    = bus_wr && (bus_addr == ADDR_W'('h04)) && !bus_wdata[0];
    assign mapped  = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h04)) ||
                     (bus_addr == ADDR_W'('h10)) || (bus_addr == ADDR_W'('h14)) ||
                     (bus_addr == ADDR_W'('h18)) || (bus_addr == ADDR_W'('h1C));

    // R3
    val_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_val0 |=> val0 == $past(bus_wdata[CNT_W-1:0]));

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_val0 && val0 != '0) |=> (val0 == $past(val0) || val0 == $past(val0) - 1'b1));

    // R7
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rl0 && val0 == '0 && !wr_val0) |=> val0 == '0);

    // R8
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0 && !clr0) |=> stat0);

    // R8
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit0 |=> stat0);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en0 |-> !irq_o[0]);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);

endmodule

bind dual_dntimer dtm_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dtm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .val0      (ch_val[0]),
    .en0       (ctrl_q[0]),
    .rl0       (ctrl_q[1]),
    .stat0     (stat_q[0]),
    .hit0      (ch_hit[0])
);

// File: tb/test_dual_dntimer.sv
module test_dual_dntimer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    dual_dntimer i_dual_dntimer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), d);
            chk("R1", d, 32'h0);
        end
        chk("R1", {30'h0, irq_o}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, d);
        chk("R2", d, 32'h01F8_180F);
        wr(5'h00, 32'h0);
        rd(5'h00, d);
        chk("R2", d, 32'h0);
    endtask

    task automatic t_load();
        logic [31:0] d;
        wr(5'h10, 32'h0000_1234);
        wr(5'h14, 32'hABCD_0001);
        rd(5'h10, d); chk("R3", d, 32'h0000_1234);
        rd(5'h14, d); chk("R3", d, 32'hABCD_0001);
        rd(5'h18, d); chk("R11", d, 32'h0);
        rd(5'h1C, d); chk("R11", d, 32'h0);
    endtask

    task automatic t_ref_count();
        logic [31:0] d;
        wr(5'h14, 32'd10);
        wr(5'h00, 32'h0000_0801);
        idle(1);
        tick(3);
        rd(5'h14, d); chk("R4", d, 32'd7);
        idle(20);
        rd(5'h14, d); chk("R5", d, 32'd7);
        wr(5'h00, 32'h0000_0800);
        tick(2);
        rd(5'h14, d); chk("R4", d, 32'd7);
    endtask

    task automatic t_prescale();
        logic [31:0] v1, v2;
        wr(5'h14, 32'd1000);
        wr(5'h00, 32'h0010_0001);
        idle(2);
        rd(5'h14, v1);
        idle(15);
        rd(5'h14, v2);
        chk("R5", v1 - v2, 32'd4);
        wr(5'h00, 32'h0028_0001);
        idle(2);
        rd(5'h14, v1);
        idle(63);
        rd(5'h14, v2);
        chk("R5", v1 - v2, 32'd2);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        wr(5'h00, 32'h0000_0800);
        wr(5'h04, 32'h0);
        wr(5'h14, 32'd3);
        wr(5'h00, 32'h0000_0801);
        idle(1);
        tick(2);
        rd(5'h04, d); chk("R8", d, 32'h0);
        tick(1);
        rd(5'h14, d); chk("R7", d, 32'h0);
        rd(5'h04, d); chk("R8", d, 32'h1);
        chk("R9", {30'h0, irq_o}, 32'h1);
        tick(3);
        rd(5'h14, d); chk("R7", d, 32'h0);
        wr(5'h04, 32'h0000_0001);
        rd(5'h04, d); chk("R8", d, 32'h1);
        wr(5'h04, 32'hFFFF_FFFE);
        rd(5'h04, d); chk("R8", d, 32'h0);
        chk("R9", {30'h0, irq_o}, 32'h0);
        tick(3);
        rd(5'h04, d); chk("R7", d, 32'h0);
        wr(5'h14, 32'd2);
        tick(2);
        rd(5'h04, d); chk("R7", d, 32'h1);
        wr(5'h00, 32'h0000_0800);
        idle(1);
        chk("R9", {30'h0, irq_o}, 32'h0);
        rd(5'h04, d); chk("R9", d, 32'h1);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wr(5'h00, 32'h0000_0801);
        wr(5'h04, 32'h0);
        wr(5'h14, 32'd1);
        idle(1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = 32'h0; ref_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ref_tick = 1'b0;
        rd(5'h04, d); chk("R8", d, 32'h1);
    endtask

    task automatic t_reload();
        logic [31:0] d;
        wr(5'h00, 32'h0000_0803);
        wr(5'h04, 32'h0);
        wr(5'h10, 32'd2);
        wr(5'h14, 32'd2);
        tick(1); rd(5'h14, d); chk("R6", d, 32'd1);
        tick(1); rd(5'h14, d); chk("R6", d, 32'd0);
        rd(5'h04, d); chk("R8", d, 32'h1);
        tick(1); rd(5'h14, d); chk("R6", d, 32'd2);
        tick(2); rd(5'h14, d); chk("R6", d, 32'd0);
        wr(5'h04, 32'h0);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'h0);
        tick(1); rd(5'h14, d); chk("R6", d, 32'hFFFF_FFFF);
        tick(1); rd(5'h14, d); chk("R6", ~d, 32'd1);
        rd(5'h04, d); chk("R8", d, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(5'h08, 32'hDEAD_BEEF);
        wr(5'h0C, 32'hDEAD_BEEF);
        rd(5'h08, d); chk("R10", d, 32'h0);
        rd(5'h0C, d); chk("R10", d, 32'h0);
        rd(5'h15, d); chk("R10", d, 32'h0);
        rd(5'h14, d); chk("R10", d, 32'hFFFF_FFFE);
        rd(5'h00, d); chk("R10", d, 32'h0000_0803);
    endtask

    task automatic t_ch1();
        logic [31:0] d;
        wr(5'h00, 32'h0000_1004);
        wr(5'h1C, 32'd2);
        idle(1);
        tick(2);
        rd(5'h04, d); chk("R11", d, 32'h0000_0100);
        chk("R9", {30'h0, irq_o}, 32'h2);
        rd(5'h14, d); chk("R11", d, 32'hFFFF_FFFE);
        wr(5'h04, 32'hFFFF_FEFF);
        rd(5'h04, d); chk("R8", d, 32'h0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_ctrl();
        t_load();
        t_ref_count();
        t_prescale();
        t_oneshot();
        t_priority();
        t_reload();
        t_unmapped();
        t_ch1();
        summary();
        $finish;
    end

endmodule